// File: doc/BRIEF.md
# Hierarchical Depth Tile Tester

This block classifies whole 8x8 pixel tiles against a coarse depth record before any per-pixel work is done. The rasterizer presents one request per tile: the tile index, the nearest and farthest depth the incoming primitive reaches inside that tile, a flag saying the primitive covers every pixel of the tile, and a depth-write enable. The block looks up the depth interval it keeps for that tile in a small register-based tile buffer and answers, one cycle later, whether the tile is certainly visible (accept), certainly hidden (reject) or undecided (unknown). An unknown answer tells the pipeline that the tile needs an exact per-pixel depth test.

Alongside the classification the block says whether the per-pixel test may run before shading. Early testing is only safe when the shader neither kills pixels nor writes its own depth, and the alpha test is switched off. The compare direction is a state input, so the same range logic serves less, less-or-equal, greater and always-pass depth functions. When a tile is accepted, fully covered and depth writes are on, the stored interval is replaced by the incoming one; in every other case it is left as it was, which keeps it conservative. A fast-clear command rewrites every tile's interval to a clear value over a fixed number of cycles, during which new requests are not taken.

Top module: `hzt_tile_tester`

## Requirements
- R1: After reset every tile stores the all-ones depth as both its near and far bound, `clear_busy` is low and `res_valid` is low.
- R2: A request is taken when `req_valid` is high while `clear_busy` and `clear_start` are both low; a taken request produces `res_valid` high on the next cycle, and `res_valid` is low in every cycle that does not follow a taken request.
- R3: With `cmp_func` = 0 (less), the result is accept (`res_class` = 1) when the incoming far bound is below the stored near bound, otherwise reject (`res_class` = 2) when the incoming near bound is at or above the stored far bound, otherwise unknown (`res_class` = 0).
- R4: With `cmp_func` = 1 (less-or-equal), accept needs the incoming far bound at or below the stored near bound, and reject needs the incoming near bound strictly above the stored far bound; anything else is unknown.
- R5: With `cmp_func` = 2 (greater), accept needs the incoming near bound strictly above the stored far bound, and reject needs the incoming far bound at or below the stored near bound; anything else is unknown.
- R6: With `cmp_func` = 3 (always), every taken request is accepted; `res_class` never takes the value 3.
- R7: `res_early` is high exactly when the taken request had `shd_discard`, `shd_zexport` and `alpha_test_en` all low.
- R8: A taken request that is accepted with `req_full` and `req_zwrite` both high replaces that tile's stored bounds with `req_zmin` and `req_zmax`, visible to a request in the very next cycle.
- R9: A taken request that is not accepted, or lacks `req_full` or `req_zwrite`, leaves the stored bounds unchanged.
- R10: `clear_start` while `clear_busy` is low raises `clear_busy` on the next cycle; it stays high for exactly TILES/CLEAR_LANES cycles, after which every tile stores `clear_value` as both bounds.
- R11: A request presented while `clear_busy` or `clear_start` is high is ignored: it yields no result and changes no stored bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Tile request present |
| req_tile | input | TILE_W | Index of the tile in the tile buffer |
| req_zmin | input | DEPTH_W | Nearest incoming depth in the tile |
| req_zmax | input | DEPTH_W | Farthest incoming depth in the tile |
| req_full | input | 1 | Primitive covers all 64 pixels of the tile |
| req_zwrite | input | 1 | Depth writes enabled |
| cmp_func | input | 2 | Depth function: 0 less, 1 less-or-equal, 2 greater, 3 always |
| shd_discard | input | 1 | Shader may kill pixels |
| shd_zexport | input | 1 | Shader writes its own depth |
| alpha_test_en | input | 1 | Alpha test enabled |
| clear_start | input | 1 | Begin fast clear of the tile buffer |
| clear_value | input | DEPTH_W | Depth written by the fast clear |
| clear_busy | output | 1 | Fast clear in progress |
| res_valid | output | 1 | Result present |
| res_class | output | 2 | 0 unknown, 1 accept, 2 reject |
| res_early | output | 1 | Per-pixel depth test may run before shading |

## Verification
The bench builds the block with an 8-bit depth, 16 tiles and four tiles cleared per cycle, so the depth extremes 0 and 255 are easy to hit, the clear lasts only four cycles and the random phase revisits every tile many times. That size puts the equal-bound edges of each compare function, back-to-back updates of one tile, and requests landing on the clear start and inside the clear window all within a short run.

// File: rtl/hzt_pkg.sv
package hzt_pkg;

    typedef enum logic [1:0] {
        CMP_LESS    = 2'd0,
        CMP_LEQUAL  = 2'd1,
        CMP_GREATER = 2'd2,
        CMP_ALWAYS  = 2'd3
    } hzt_cmp_e;

    typedef enum logic [1:0] {
        CLS_UNKNOWN = 2'd0,
        CLS_ACCEPT  = 2'd1,
        CLS_REJECT  = 2'd2
    } hzt_class_e;

    typedef struct packed {
        logic discard;
        logic zexport;
        logic alpha_test;
    } hzt_shade_t;

    typedef struct packed {
        logic       valid;
        hzt_class_e cls;
        logic       early;
    } hzt_result_t;

    function automatic int unsigned hzt_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Range test on zero-extended depths; accept is tested first.
    function automatic hzt_class_e hzt_classify(
        input hzt_cmp_e    fn,
        input logic [31:0] in_lo,
        input logic [31:0] in_hi,
        input logic [31:0] st_lo,
        input logic [31:0] st_hi
    );
        logic acc;
        logic rej;
        acc = 1'b0;
        rej = 1'b0;
        unique case (fn)
            CMP_LESS: begin
                acc = in_hi <  st_lo;
                rej = in_lo >= st_hi;
            end
            CMP_LEQUAL: begin
                acc = in_hi <= st_lo;
                rej = in_lo >  st_hi;
            end
            CMP_GREATER: begin
                acc = in_lo >  st_hi;
                rej = in_hi <= st_lo;
            end
            default: begin
                acc = 1'b1;
                rej = 1'b0;
            end
        endcase
        if (acc)      return CLS_ACCEPT;
        else if (rej) return CLS_REJECT;
        else          return CLS_UNKNOWN;
    endfunction

    function automatic logic hzt_early_ok(input hzt_shade_t s);
        return !(s.discard || s.zexport || s.alpha_test);
    endfunction

endpackage

// File: rtl/hzt_range_cmp.sv
module hzt_range_cmp
    import hzt_pkg::*;
#(
    parameter int unsigned DEPTH_W = 16
) (
    input  hzt_cmp_e           fn,
    input  logic [DEPTH_W-1:0] in_lo,
    input  logic [DEPTH_W-1:0] in_hi,
    input  logic [DEPTH_W-1:0] st_lo,
    input  logic [DEPTH_W-1:0] st_hi,
    output hzt_class_e         cls
);

    always_comb begin
        cls = hzt_classify(fn, 32'(in_lo), 32'(in_hi), 32'(st_lo), 32'(st_hi));
    end

endmodule

// File: rtl/hzt_clear_seq.sv
module hzt_clear_seq
    import hzt_pkg::*;
#(
    parameter int unsigned DEPTH_W     = 16,
    parameter int unsigned TILES       = 64,
    parameter int unsigned CLEAR_LANES = 4,
    parameter int unsigned ROUND_W     = hzt_bits(TILES / CLEAR_LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DEPTH_W-1:0] value,
    output logic               busy,
    output logic [ROUND_W-1:0] round,
    output logic [DEPTH_W-1:0] fill
);

    localparam int unsigned ROUNDS = TILES / CLEAR_LANES;
    localparam logic [ROUND_W-1:0] LAST = ROUND_W'(ROUNDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            round <= '0;
            fill  <= '0;
        end else if (!busy && start) begin
            busy  <= 1'b1;
            round <= '0;
            fill  <= value;
        end else if (busy) begin
            if (round == LAST) begin
                busy <= 1'b0;
            end
            round <= round + 1'b1;
        end
    end

endmodule

// File: rtl/hzt_tile_store.sv
module hzt_tile_store
    import hzt_pkg::*;
#(
    parameter int unsigned DEPTH_W     = 16,
    parameter int unsigned TILES       = 64,
    parameter int unsigned CLEAR_LANES = 4,
    parameter int unsigned TILE_W      = hzt_bits(TILES),
    parameter int unsigned ROUND_W     = hzt_bits(TILES / CLEAR_LANES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TILE_W-1:0]  rd_tile,
    output logic [DEPTH_W-1:0] rd_lo,
    output logic [DEPTH_W-1:0] rd_hi,
    input  logic               upd_en,
    input  logic [TILE_W-1:0]  upd_tile,
    input  logic [DEPTH_W-1:0] upd_lo,
    input  logic [DEPTH_W-1:0] upd_hi,
    input  logic               clr_en,
    input  logic [ROUND_W-1:0] clr_round,
    input  logic [DEPTH_W-1:0] clr_val
);

    logic [DEPTH_W-1:0] lo_view [TILES];
    logic [DEPTH_W-1:0] hi_view [TILES];

    for (genvar g = 0; g < TILES; g++) begin : g_tile
        localparam int unsigned MY_ROUND = g / CLEAR_LANES;
        logic [DEPTH_W-1:0] lo_q;
        logic [DEPTH_W-1:0] hi_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= '1;
                hi_q <= '1;
            end else if (clr_en && clr_round == ROUND_W'(MY_ROUND)) begin
                lo_q <= clr_val;
                hi_q <= clr_val;
            end else if (upd_en && upd_tile == TILE_W'(g)) begin
                lo_q <= upd_lo;
                hi_q <= upd_hi;
            end
        end

        assign lo_view[g] = lo_q;
        assign hi_view[g] = hi_q;
    end

    always_comb begin
        rd_lo = '1;
        rd_hi = '1;
        for (int t = 0; t < TILES; t++) begin
            if (rd_tile == TILE_W'(t)) begin
                rd_lo = lo_view[t];
                rd_hi = hi_view[t];
            end
        end
    end

endmodule

// File: rtl/hzt_tile_tester.sv
module hzt_tile_tester
    import hzt_pkg::*;
#(
    parameter int unsigned DEPTH_W     = 16,
    parameter int unsigned TILES       = 64,
    parameter int unsigned CLEAR_LANES = 4,
    parameter int unsigned TILE_W      = hzt_bits(TILES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [TILE_W-1:0]  req_tile,
    input  logic [DEPTH_W-1:0] req_zmin,
    input  logic [DEPTH_W-1:0] req_zmax,
    input  logic               req_full,
    input  logic               req_zwrite,
    input  logic [1:0]         cmp_func,
    input  logic               shd_discard,
    input  logic               shd_zexport,
    input  logic               alpha_test_en,
    input  logic               clear_start,
    input  logic [DEPTH_W-1:0] clear_value,
    output logic               clear_busy,
    output logic               res_valid,
    output logic [1:0]         res_class,
    output logic               res_early
);

    localparam int unsigned ROUND_W = hzt_bits(TILES / CLEAR_LANES);

    logic               take;
    logic [DEPTH_W-1:0] st_lo;
    logic [DEPTH_W-1:0] st_hi;
    hzt_class_e         cls;
    hzt_shade_t         shade;
    logic               upd_en;
    logic [ROUND_W-1:0] clr_round;
    logic [DEPTH_W-1:0] clr_fill;
    hzt_result_t        res_q;

    assign take  = req_valid && !clear_busy && !clear_start;
    assign shade = '{discard: shd_discard, zexport: shd_zexport, alpha_test: alpha_test_en};

    hzt_clear_seq #(
        .DEPTH_W(DEPTH_W), .TILES(TILES), .CLEAR_LANES(CLEAR_LANES), .ROUND_W(ROUND_W)
    ) u_clear (
        .clk(clk), .rst(rst), .start(clear_start), .value(clear_value),
        .busy(clear_busy), .round(clr_round), .fill(clr_fill)
    );

    hzt_tile_store #(
        .DEPTH_W(DEPTH_W), .TILES(TILES), .CLEAR_LANES(CLEAR_LANES),
        .TILE_W(TILE_W), .ROUND_W(ROUND_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .rd_tile(req_tile), .rd_lo(st_lo), .rd_hi(st_hi),
        .upd_en(upd_en), .upd_tile(req_tile), .upd_lo(req_zmin), .upd_hi(req_zmax),
        .clr_en(clear_busy), .clr_round(clr_round), .clr_val(clr_fill)
    );

    hzt_range_cmp #(.DEPTH_W(DEPTH_W)) u_cmp (
        .fn(hzt_cmp_e'(cmp_func)), .in_lo(req_zmin), .in_hi(req_zmax),
        .st_lo(st_lo), .st_hi(st_hi), .cls(cls)
    );

    assign upd_en = take && (cls == CLS_ACCEPT) && req_full && req_zwrite;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, cls: CLS_UNKNOWN, early: 1'b0};
        end else begin
            res_q.valid <= take;
            if (take) begin
                res_q.cls   <= cls;
                res_q.early <= hzt_early_ok(shade);
            end
        end
    end

    assign res_valid = res_q.valid;
    assign res_class = res_q.cls;
    assign res_early = res_q.early;

endmodule

// File: rtl/hzt_tile_tester_chk.sv
module hzt_tile_tester_chk #(
    parameter int unsigned DEPTH_W     = 16,
    parameter int unsigned TILES       = 64,
    parameter int unsigned CLEAR_LANES = 4,
    parameter int unsigned TILE_W      = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [TILE_W-1:0]  req_tile,
    input logic [DEPTH_W-1:0] req_zmin,
    input logic [DEPTH_W-1:0] req_zmax,
    input logic               req_full,
    input logic               req_zwrite,
    input logic [1:0]         cmp_func,
    input logic               shd_discard,
    input logic               shd_zexport,
    input logic               alpha_test_en,
    input logic               clear_start,
    input logic [DEPTH_W-1:0] clear_value,
    input logic               clear_busy,
    input logic               res_valid,
    input logic [1:0]         res_class,
    input logic               res_early
);

    localparam int ROUNDS = int'(TILES / CLEAR_LANES);

    int busy_cnt;
    logic taken;

    assign taken = req_valid && !clear_busy && !clear_start;

    always_ff @(posedge clk) begin
        if (rst)             busy_cnt <= 0;
        else if (clear_busy) busy_cnt <= busy_cnt + 1;
        else                 busy_cnt <= 0;
    end

    // R2
    result_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> res_valid);

    // R11
    blocked_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !taken |=> !res_valid);

    // R10
    clear_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_start && !clear_busy) |=> clear_busy);

    // R10
    clear_holds_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_busy && busy_cnt < ROUNDS - 1) |=> clear_busy);

    // R10
    clear_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_busy && busy_cnt == ROUNDS - 1) |=> !clear_busy);

    // R6
    class_legal_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_class != 2'd3);

    // R6
    always_accepts_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && cmp_func == 2'd3) |=> res_class == 2'd1);

    // R7
    early_flag_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> res_early == !($past(shd_discard) || $past(shd_zexport) || $past(alpha_test_en)));

endmodule

bind hzt_tile_tester hzt_tile_tester_chk #(
    .DEPTH_W(DEPTH_W), .TILES(TILES), .CLEAR_LANES(CLEAR_LANES), .TILE_W(TILE_W)
) chk_i (.*);

// File: tb/hzt_tile_tester_tb_top.sv
`timescale 1ns/1ps
module hzt_tile_tester_tb_top;

    localparam int DW    = 8;
    localparam int NT    = 16;
    localparam int LANES = 4;
    localparam int TW    = 4;
    localparam int MAXZ  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [TW-1:0] req_tile = '0;
    logic [DW-1:0] req_zmin = '0;
    logic [DW-1:0] req_zmax = '0;
    logic          req_full = 1'b0;
    logic          req_zwrite = 1'b0;
    logic [1:0]    cmp_func = 2'd0;
    logic          shd_discard = 1'b0;
    logic          shd_zexport = 1'b0;
    logic          alpha_test_en = 1'b0;
    logic          clear_start = 1'b0;
    logic [DW-1:0] clear_value = '0;
    logic          clear_busy;
    logic          res_valid;
    logic [1:0]    res_class;
    logic          res_early;

    always #2.5 clk = ~clk;

    hzt_tile_tester #(.DEPTH_W(DW), .TILES(NT), .CLEAR_LANES(LANES), .TILE_W(TW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_tile(req_tile),
        .req_zmin(req_zmin), .req_zmax(req_zmax), .req_full(req_full),
        .req_zwrite(req_zwrite), .cmp_func(cmp_func), .shd_discard(shd_discard),
        .shd_zexport(shd_zexport), .alpha_test_en(alpha_test_en),
        .clear_start(clear_start), .clear_value(clear_value),
        .clear_busy(clear_busy), .res_valid(res_valid), .res_class(res_class),
        .res_early(res_early)
    );

    // Reference model state
    int m_lo [NT];
    int m_hi [NT];
    int e_valid, e_class, e_early, e_busy, left, cval;
    bit started = 0;
    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    function automatic int ref_class(int f, int mn, int mx, int lo, int hi);
        if (f == 3) return 1;
        if (f == 0) begin
            if (mx < lo) return 1;
            if (mn >= hi) return 2;
        end else if (f == 1) begin
            if (mx <= lo) return 1;
            if (mn > hi) return 2;
        end else begin
            if (mn > hi) return 1;
            if (mx <= lo) return 2;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            foreach (m_lo[i]) begin m_lo[i] = MAXZ; m_hi[i] = MAXZ; end
            e_valid = 0; e_class = 0; e_early = 0; e_busy = 0; left = 0; cval = 0;
        end else begin
            int t;
            int c;
            if (req_valid && !e_busy && !clear_start) begin
                t = int'(req_tile);
                c = ref_class(int'(cmp_func), int'(req_zmin), int'(req_zmax), m_lo[t], m_hi[t]);
                e_valid = 1;
                e_class = c;
                e_early = (!shd_discard && !shd_zexport && !alpha_test_en) ? 1 : 0;
                if (c == 1 && req_full && req_zwrite) begin
                    m_lo[t] = int'(req_zmin);
                    m_hi[t] = int'(req_zmax);
                end
            end else begin
                e_valid = 0;
            end
            if (clear_start && !e_busy) begin
                e_busy = 1; left = NT / LANES; cval = int'(clear_value);
            end else if (e_busy) begin
                left--;
                if (left == 0) begin
                    e_busy = 0;
                    foreach (m_lo[i]) begin m_lo[i] = cval; m_hi[i] = cval; end
                end
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("R10", "clear_busy", int'(clear_busy), e_busy);
            check(cur_req == "R11" ? "R11" : "R2", "res_valid", int'(res_valid), e_valid);
            if (e_valid) begin
                check(cur_req, "res_class", int'(res_class), e_class);
                check("R7", "res_early", int'(res_early), e_early);
            end
        end
    end

    task automatic send(int tile, int mn, int mx, int full, int wr, int f,
                        int d = 0, int z = 0, int a = 0);
        req_valid = 1'b1;
        req_tile = TW'(tile); req_zmin = DW'(mn); req_zmax = DW'(mx);
        req_full = full[0]; req_zwrite = wr[0]; cmp_func = f[1:0];
        shd_discard = d[0]; shd_zexport = z[0]; alpha_test_en = a[0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: all tiles start at the far bound; probe a few
        cur_req = "R1";
        check("R1", "busy after reset", int'(clear_busy), 0);
        check("R1", "valid after reset", int'(res_valid), 0);
        send(0, 0, 0, 0, 0, 0);
        send(5, MAXZ, MAXZ, 0, 0, 0);
        send(15, 254, 254, 0, 0, 0);
        // R8: load tile 3 with [100,120]
        cur_req = "R8";
        send(3, 100, 120, 1, 1, 0);
        send(3, 10, 20, 0, 0, 0);
        send(3, 100, 120, 1, 1, 0);
        // R3 less boundaries
        cur_req = "R3";
        send(3, 50, 99, 0, 0, 0);
        send(3, 50, 100, 0, 0, 0);
        send(3, 120, 200, 0, 0, 0);
        send(3, 119, 200, 0, 0, 0);
        // R4 less-equal boundaries
        cur_req = "R4";
        send(3, 50, 100, 0, 0, 1);
        send(3, 50, 101, 0, 0, 1);
        send(3, 120, 200, 0, 0, 1);
        send(3, 121, 200, 0, 0, 1);
        // R5 greater boundaries
        cur_req = "R5";
        send(3, 121, 200, 0, 0, 2);
        send(3, 120, 200, 0, 0, 2);
        send(3, 10, 100, 0, 0, 2);
        send(3, 10, 101, 0, 0, 2);
        // R6 always
        cur_req = "R6";
        send(3, 200, 250, 0, 0, 3);
        send(7, 0, 255, 0, 0, 3);
        // R7 early flag combinations
        cur_req = "R7";
        send(3, 0, 1, 0, 0, 0, 1, 0, 0);
        send(3, 0, 1, 0, 0, 0, 0, 1, 0);
        send(3, 0, 1, 0, 0, 0, 0, 0, 1);
        send(3, 0, 1, 0, 0, 0, 0, 0, 0);
        // R9: accept without full / without write, reject with both
        cur_req = "R9";
        send(3, 10, 20, 0, 1, 0);
        send(3, 10, 20, 1, 0, 0);
        send(3, 200, 220, 1, 1, 0);
        send(3, 99, 99, 0, 0, 0);
        send(3, 100, 100, 0, 0, 0);
        // R8: back-to-back updates on the same tile
        cur_req = "R8";
        send(9, 30, 40, 1, 1, 0);
        send(9, 10, 20, 1, 1, 0);
        send(9, 15, 25, 0, 0, 0);
        idle(2);
        // R10 / R11: clear with a request on the start cycle and inside the window
        cur_req = "R11";
        clear_value = DW'(50);
        clear_start = 1'b1;
        send(9, 0, 1, 1, 1, 0);
        clear_start = 1'b0;
        send(4, 0, 1, 1, 1, 0);
        send(4, 0, 2, 1, 1, 0);
        idle(4);
        cur_req = "R10";
        send(4, 0, 49, 0, 0, 0);
        send(9, 49, 50, 0, 0, 0);
        send(12, 50, 60, 0, 0, 0);
        // Random mix against the model
        cur_req = "R8";
        for (int n = 0; n < 600; n++) begin
            int a = $urandom_range(0, MAXZ);
            int b = $urandom_range(0, MAXZ);
            int lo = (a < b) ? a : b;
            int hi = (a < b) ? b : a;
            if ($urandom_range(0, 40) == 0) begin
                clear_value = DW'($urandom_range(0, MAXZ));
                clear_start = 1'b1;
            end
            send($urandom_range(0, NT - 1), lo, hi, $urandom_range(0, 1),
                 $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
            clear_start = 1'b0;
        end
        idle(6);
        finish_run();
    end

endmodule